// File: doc/BRIEF.md
# Effective Address Qualifier and Fault Router

This block is the entry stage of a 64-bit address translation unit. It accepts one effective address at a time, together with an access kind (load, store or fetch) and four machine-state bits: hypervisor, problem state, instruction relocate and data relocate. When relocation is off for the access kind, the block forms the real address itself and answers at once. When relocation is on, the block uses the two top address bits (the quadrant) to qualify the address with a partition ID and a process ID. It then passes the qualified request to a downstream table walker through a valid/ready handshake and waits for the walker's verdict.

Faults are sorted into four interrupt classes. A segment fault comes from an illegal quadrant. A storage fault is reported by the walker. Each class is split into an instruction flavour and a data flavour. The block fills a fault-address register, a data-storage syndrome and an instruction error code as the class requires. The response is held on the output until the requester acknowledges it.

The controller has four states:
- IDLE: ready for a request. On a request it moves to RESP for real mode or an illegal quadrant, and to WREQ otherwise.
- WREQ: offering the request to the walker. It moves to WWAIT on `wlk_ready`.
- WWAIT: waiting for the walker verdict. It moves to RESP on `wlk_done`.
- RESP: response valid. It moves to IDLE on `rsp_ack`.

Top module: `eaq_router`

## Requirements
- R1: Access codes are 0 load, 1 store, 2 fetch, and 3 is treated as a load. Real mode applies to a fetch when `msr_ir`=0 and to any other access when `msr_dr`=0. In real mode the response address is the effective address with bits 63:60 cleared.
- R2: In real mode, when `msr_hv`=1 and effective address bit 63 is 0, `hrmor` is ORed into the cleared address. Otherwise it is not.
- R3: A real-mode response carries `rsp_prot`=3'b111 (bit0 read, bit1 write, bit2 execute), `rsp_psize`=12, `rsp_exc`=0 and zero syndrome fields. No walker request is issued for it.
- R4: In virtual mode, quadrant 0 (EA[63:62]=00) sends the walker `lpid_reg` as the partition ID and `pid_reg` as the process ID.
- R5: Quadrant 3 (EA[63:62]=11) sends `lpid_reg` and a process ID of 0.
- R6: Quadrants 1 and 2 in virtual mode raise a segment fault without a walk. A fetch gets `rsp_exc`=1 (instruction segment) with `rsp_dar`=0. A load or store gets `rsp_exc`=2 (data segment) with `rsp_dar` set to the effective address.
- R7: A walker fault on a fetch gives `rsp_exc`=3 (instruction storage), `rsp_err`=`wlk_cause`, and `rsp_dar`=0 and `rsp_dsisr`=0.
- R8: A walker fault on a load or store gives `rsp_exc`=4 (data storage) and `rsp_dar` set to the effective address. `rsp_dsisr` is `wlk_cause` with bit 25 also set when the access was a store. `rsp_err`=0.
- R9: The walker receives the effective address with bits 63:62 cleared, plus the access code and the problem-state bit. These are held stable while `wlk_valid` is high and `wlk_ready` is low.
- R10: Only one request is in flight. `req_ready` is high only in IDLE. The response and its fields are held until `rsp_ack`.
- R11: A walker success copies `wlk_ra`, `wlk_psize` and `wlk_prot` into the response, with `rsp_exc`=0 and zero syndrome fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_ea | input | 64 | Effective address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| msr_hv | input | 1 | Hypervisor state |
| msr_pr | input | 1 | Problem (user) state |
| msr_ir | input | 1 | Instruction relocate enable |
| msr_dr | input | 1 | Data relocate enable |
| lpid_reg | input | 12 | Current partition ID |
| pid_reg | input | 20 | Current process ID |
| hrmor | input | 64 | Hypervisor real-mode offset |
| wlk_valid | output | 1 | Qualified request to walker |
| wlk_ready | input | 1 | Walker accepts request |
| wlk_ea | output | 64 | Address with quadrant bits cleared |
| wlk_acc | output | 2 | Access kind to walker |
| wlk_prob | output | 1 | Problem state to walker |
| wlk_lpid | output | 12 | Partition ID to walker |
| wlk_pid | output | 20 | Process ID to walker |
| wlk_done | input | 1 | Walker verdict pulse |
| wlk_fault | input | 1 | Verdict is a storage fault |
| wlk_cause | input | 32 | Storage fault cause code |
| wlk_ra | input | 64 | Translated real address |
| wlk_psize | input | 6 | Log2 page size |
| wlk_prot | input | 3 | Granted permissions |
| rsp_valid | output | 1 | Response held |
| rsp_ack | input | 1 | Requester takes response |
| rsp_ra | output | 64 | Real address |
| rsp_psize | output | 6 | Log2 page size |
| rsp_prot | output | 3 | Permissions {exec, write, read} |
| rsp_exc | output | 3 | 0 none, 1 ISEG, 2 DSEG, 3 ISI, 4 DSI |
| rsp_dar | output | 64 | Faulting data address |
| rsp_dsisr | output | 32 | Data storage syndrome |
| rsp_err | output | 32 | Instruction fault error code |

## Verification
The assertions assume a walker that raises `wlk_done` only after it has taken a request, and that holds its result inputs steady in that cycle. They also assume a requester that keeps `req_ea`, `req_acc` and the state bits steady while `req_valid` is high. The bench's walker stub waits for `wlk_valid`, and then for its own ready delay, before it answers. The requester task changes its inputs only after it has seen the request accepted. All stalls on the walker and acknowledge sides come from bench-chosen delays, so hold behaviour is exercised without breaking these rules.

// File: rtl/eaq_pkg.sv
package eaq_pkg;
    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_ISEG = 3'd1,
        EXC_DSEG = 3'd2,
        EXC_ISI  = 3'd3,
        EXC_DSI  = 3'd4
    } exc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WREQ  = 2'd1,
        ST_WWAIT = 2'd2,
        ST_RESP  = 2'd3
    } st_e;
endpackage

// File: rtl/eaq_real_map.sv
module eaq_real_map #(
    parameter int EA_W = 64
) (
    input  logic [EA_W-1:0] ea,
    input  logic [1:0]      acc,
    input  logic            hv,
    input  logic            ir,
    input  logic            dr,
    input  logic [EA_W-1:0] offset,
    output logic            is_real,
    output logic [EA_W-1:0] ra
);
    import eaq_pkg::*;
    localparam int KEEP_W = EA_W - 4;

    logic [EA_W-1:0] masked;

    always_comb begin
        is_real = (acc == ACC_FETCH) ? !ir : !dr;
        masked  = {4'b0000, ea[KEEP_W-1:0]};
        ra      = (hv && !ea[EA_W-1]) ? (masked | offset) : masked;
    end
endmodule

// File: rtl/eaq_quadrant.sv
module eaq_quadrant #(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic [1:0]        quad,
    input  logic [LPID_W-1:0] lpid_in,
    input  logic [PID_W-1:0]  pid_in,
    output logic              illegal,
    output logic [LPID_W-1:0] lpid_out,
    output logic [PID_W-1:0]  pid_out
);
    always_comb begin
        lpid_out = lpid_in;
        pid_out  = '0;
        illegal  = 1'b0;
        unique case (quad)
            2'b00: pid_out = pid_in;
            2'b11: pid_out = '0;
            2'b01, 2'b10: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/eaq_fault_fmt.sv
module eaq_fault_fmt #(
    parameter int EA_W      = 64,
    parameter int CAUSE_W   = 32,
    parameter int STORE_BIT = 25
) (
    input  logic               is_seg,
    input  logic [1:0]         acc,
    input  logic [EA_W-1:0]    ea,
    input  logic [CAUSE_W-1:0] cause,
    output eaq_pkg::exc_e      exc,
    output logic [EA_W-1:0]    dar,
    output logic [CAUSE_W-1:0] dsisr,
    output logic [CAUSE_W-1:0] err
);
    import eaq_pkg::*;
    localparam logic [CAUSE_W-1:0] STORE_FLAG = CAUSE_W'(1) << STORE_BIT;

    logic is_fetch;

    always_comb begin
        is_fetch = (acc == ACC_FETCH);
        dar      = '0;
        dsisr    = '0;
        err      = '0;
        if (is_seg) begin
            exc = is_fetch ? EXC_ISEG : EXC_DSEG;
            if (!is_fetch) dar = ea;
        end else if (is_fetch) begin
            exc = EXC_ISI;
            err = cause;
        end else begin
            exc   = EXC_DSI;
            dar   = ea;
            dsisr = (acc == ACC_STORE) ? (cause | STORE_FLAG) : cause;
        end
    end
endmodule

// File: rtl/eaq_router.sv
module eaq_router #(
    parameter int EA_W       = 64,
    parameter int LPID_W     = 12,
    parameter int PID_W      = 20,
    parameter int CAUSE_W    = 32,
    parameter int PSZ_W      = 6,
    parameter int STORE_BIT  = 25,
    parameter int REAL_PSIZE = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [EA_W-1:0]    req_ea,
    input  logic [1:0]         req_acc,
    input  logic               msr_hv,
    input  logic               msr_pr,
    input  logic               msr_ir,
    input  logic               msr_dr,
    input  logic [LPID_W-1:0]  lpid_reg,
    input  logic [PID_W-1:0]   pid_reg,
    input  logic [EA_W-1:0]    hrmor,
    output logic               wlk_valid,
    input  logic               wlk_ready,
    output logic [EA_W-1:0]    wlk_ea,
    output logic [1:0]         wlk_acc,
    output logic               wlk_prob,
    output logic [LPID_W-1:0]  wlk_lpid,
    output logic [PID_W-1:0]   wlk_pid,
    input  logic               wlk_done,
    input  logic               wlk_fault,
    input  logic [CAUSE_W-1:0] wlk_cause,
    input  logic [EA_W-1:0]    wlk_ra,
    input  logic [PSZ_W-1:0]   wlk_psize,
    input  logic [2:0]         wlk_prot,
    output logic               rsp_valid,
    input  logic               rsp_ack,
    output logic [EA_W-1:0]    rsp_ra,
    output logic [PSZ_W-1:0]   rsp_psize,
    output logic [2:0]         rsp_prot,
    output logic [2:0]         rsp_exc,
    output logic [EA_W-1:0]    rsp_dar,
    output logic [CAUSE_W-1:0] rsp_dsisr,
    output logic [CAUSE_W-1:0] rsp_err
);
    import eaq_pkg::*;
    localparam int QHI = EA_W - 1;
    localparam int QLO = EA_W - 2;
    localparam logic [PSZ_W-1:0] REAL_PSZ = PSZ_W'(REAL_PSIZE);

    st_e st, st_nx;

    logic              rm_real;
    logic [EA_W-1:0]   rm_ra;
    logic              q_bad;
    logic [LPID_W-1:0] q_lpid;
    logic [PID_W-1:0]  q_pid;
    exc_e              f_exc;
    logic [EA_W-1:0]   f_dar;
    logic [CAUSE_W-1:0] f_dsisr, f_err;

    logic [EA_W-1:0]   c_ea;
    logic [1:0]        c_acc;
    logic [EA_W-1:0]   w_ea;
    logic [1:0]        w_acc;
    logic              w_prob;
    logic [LPID_W-1:0] w_lpid;
    logic [PID_W-1:0]  w_pid;
    logic [EA_W-1:0]   r_ra, r_dar;
    logic [PSZ_W-1:0]  r_psz;
    logic [2:0]        r_prot;
    exc_e              r_exc;
    logic [CAUSE_W-1:0] r_dsisr, r_err;

    eaq_real_map #(.EA_W(EA_W)) u_real (
        .ea(req_ea), .acc(req_acc), .hv(msr_hv), .ir(msr_ir), .dr(msr_dr),
        .offset(hrmor), .is_real(rm_real), .ra(rm_ra)
    );

    eaq_quadrant #(.LPID_W(LPID_W), .PID_W(PID_W)) u_quad (
        .quad(req_ea[QHI:QLO]), .lpid_in(lpid_reg), .pid_in(pid_reg),
        .illegal(q_bad), .lpid_out(q_lpid), .pid_out(q_pid)
    );

    eaq_fault_fmt #(.EA_W(EA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) u_fmt (
        .is_seg(st == ST_IDLE),
        .acc((st == ST_IDLE) ? req_acc : c_acc),
        .ea((st == ST_IDLE) ? req_ea : c_ea),
        .cause(wlk_cause),
        .exc(f_exc), .dar(f_dar), .dsisr(f_dsisr), .err(f_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (req_valid) st_nx = (rm_real || q_bad) ? ST_RESP : ST_WREQ;
            ST_WREQ:  if (wlk_ready) st_nx = ST_WWAIT;
            ST_WWAIT: if (wlk_done)  st_nx = ST_RESP;
            ST_RESP:  if (rsp_ack)   st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (st == ST_IDLE);
        wlk_valid = (st == ST_WREQ);
        rsp_valid = (st == ST_RESP);
        wlk_ea    = w_ea;
        wlk_acc   = w_acc;
        wlk_prob  = w_prob;
        wlk_lpid  = w_lpid;
        wlk_pid   = w_pid;
        rsp_ra    = r_ra;
        rsp_psize = r_psz;
        rsp_prot  = r_prot;
        rsp_exc   = r_exc;
        rsp_dar   = r_dar;
        rsp_dsisr = r_dsisr;
        rsp_err   = r_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_ea <= '0; c_acc <= '0;
            w_ea <= '0; w_acc <= '0; w_prob <= 1'b0; w_lpid <= '0; w_pid <= '0;
            r_ra <= '0; r_psz <= '0; r_prot <= '0; r_exc <= EXC_NONE;
            r_dar <= '0; r_dsisr <= '0; r_err <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    c_ea   <= req_ea;
                    c_acc  <= req_acc;
                    w_ea   <= {2'b00, req_ea[QLO-1:0]};
                    w_acc  <= req_acc;
                    w_prob <= msr_pr;
                    w_lpid <= q_lpid;
                    w_pid  <= q_pid;
                    if (rm_real) begin
                        r_ra <= rm_ra; r_psz <= REAL_PSZ; r_prot <= 3'b111;
                        r_exc <= EXC_NONE; r_dar <= '0; r_dsisr <= '0; r_err <= '0;
                    end else if (q_bad) begin
                        r_ra <= '0; r_psz <= '0; r_prot <= '0;
                        r_exc <= f_exc; r_dar <= f_dar; r_dsisr <= f_dsisr; r_err <= f_err;
                    end
                end
                ST_WWAIT: if (wlk_done) begin
                    if (wlk_fault) begin
                        r_ra <= '0; r_psz <= '0; r_prot <= '0;
                        r_exc <= f_exc; r_dar <= f_dar; r_dsisr <= f_dsisr; r_err <= f_err;
                    end else begin
                        r_ra <= wlk_ra; r_psz <= wlk_psize; r_prot <= wlk_prot;
                        r_exc <= EXC_NONE; r_dar <= '0; r_dsisr <= '0; r_err <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    logic acc_real, acc_virt;
    assign acc_real = (st == ST_IDLE) && req_valid && rm_real;
    assign acc_virt = (st == ST_IDLE) && req_valid && !rm_real;

    AST_REAL_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_real && !msr_hv |=> rsp_valid && (rsp_ra[EA_W-1:EA_W-4] == 4'h0)); // R1
    AST_REAL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_real |=> rsp_valid && rsp_prot == 3'b111 && rsp_exc == 3'd0); // R3
    AST_Q3_PID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc_virt && req_ea[QHI:QLO] == 2'b11 |=> wlk_valid && wlk_pid == '0); // R5
    AST_BAD_QUAD_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        acc_virt && (req_ea[QHI] ^ req_ea[QLO]) |=> rsp_valid && (rsp_exc == 3'd1 || rsp_exc == 3'd2)); // R6
    AST_WLK_EA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wlk_valid |-> wlk_ea[QHI:QLO] == 2'b00); // R9
    AST_WLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wlk_valid && !wlk_ready |=> wlk_valid && $stable(wlk_ea) && $stable(wlk_pid)); // R9
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_ra) && $stable(rsp_exc) && $stable(rsp_dsisr)); // R10
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, wlk_valid, rsp_valid})); // R10
endmodule

// File: tb/eaq_router_bench.sv
module eaq_router_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [63:0] req_ea = '0;
    logic [1:0] req_acc = '0;
    logic msr_hv = 0, msr_pr = 0, msr_ir = 1, msr_dr = 1;
    logic [11:0] lpid_reg = 12'h5A3;
    logic [19:0] pid_reg = 20'h1BEEF;
    logic [63:0] hrmor = 64'h0000_0000_4000_0000;
    logic wlk_valid, wlk_ready = 0;
    logic [63:0] wlk_ea;
    logic [1:0] wlk_acc;
    logic wlk_prob;
    logic [11:0] wlk_lpid;
    logic [19:0] wlk_pid;
    logic wlk_done = 0, wlk_fault = 0;
    logic [31:0] wlk_cause = '0;
    logic [63:0] wlk_ra = '0;
    logic [5:0] wlk_psize = '0;
    logic [2:0] wlk_prot = '0;
    logic rsp_valid, rsp_ack = 0;
    logic [63:0] rsp_ra, rsp_dar;
    logic [5:0] rsp_psize;
    logic [2:0] rsp_prot, rsp_exc;
    logic [31:0] rsp_dsisr, rsp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    eaq_router u_eaq_router (.*);

    int total = 0, bad = 0;
    int g_rdy_dly = 0, g_done_dly = 0, g_ack_dly = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_st = 0;
    string m_tag = "R10";
    logic [63:0] e_ra, e_dar, e_wea, m_ea;
    logic [5:0] e_psz;
    logic [2:0] e_prot, e_exc;
    logic [31:0] e_dsisr, e_err;
    logic [11:0] e_wlpid;
    logic [19:0] e_wpid;
    logic [1:0] e_wacc, m_acc;
    logic e_wprob;

    always @(posedge clk) begin
        if (!rst_n) m_st = 0;
        else begin
            case (m_st)
                0: if (req_valid) begin
                    logic [1:0] q;
                    bit fetch;
                    q = req_ea[63:62];
                    fetch = (req_acc == 2'd2);
                    if (fetch ? !msr_ir : !msr_dr) begin
                        e_ra = req_ea & 64'h0FFF_FFFF_FFFF_FFFF;
                        if (msr_hv && !req_ea[63]) e_ra = e_ra | hrmor;
                        e_psz = 6'd12; e_prot = 3'b111; e_exc = 3'd0;
                        e_dar = '0; e_dsisr = '0; e_err = '0;
                        m_tag = msr_hv ? "R2 real hv" : "R1/R3 real";
                        m_st = 3;
                    end else if (q == 2'b01 || q == 2'b10) begin
                        e_ra = '0; e_psz = '0; e_prot = '0;
                        e_exc = fetch ? 3'd1 : 3'd2;
                        e_dar = fetch ? 64'd0 : req_ea;
                        e_dsisr = '0; e_err = '0;
                        m_tag = "R6 segment";
                        m_st = 3;
                    end else begin
                        e_wea = req_ea & 64'h3FFF_FFFF_FFFF_FFFF;
                        e_wlpid = lpid_reg;
                        e_wpid = (q == 2'b11) ? 20'd0 : pid_reg;
                        e_wacc = req_acc; e_wprob = msr_pr;
                        m_ea = req_ea; m_acc = req_acc;
                        m_tag = (q == 2'b11) ? "R5 quad3" : "R4 quad0";
                        m_st = 1;
                    end
                end
                1: if (wlk_ready) m_st = 2;
                2: if (wlk_done) begin
                    if (wlk_fault) begin
                        e_ra = '0; e_psz = '0; e_prot = '0;
                        if (m_acc == 2'd2) begin
                            e_exc = 3'd3; e_err = wlk_cause; e_dar = '0; e_dsisr = '0;
                            m_tag = "R7 fetch storage";
                        end else begin
                            e_exc = 3'd4; e_err = '0; e_dar = m_ea;
                            e_dsisr = wlk_cause | ((m_acc == 2'd1) ? 32'h0200_0000 : 32'h0);
                            m_tag = "R8 data storage";
                        end
                    end else begin
                        e_ra = wlk_ra; e_psz = wlk_psize; e_prot = wlk_prot;
                        e_exc = 3'd0; e_dar = '0; e_dsisr = '0; e_err = '0;
                        m_tag = "R11 success";
                    end
                    m_st = 3;
                end
                3: if (rsp_ack) m_st = 0;
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) if (rst_n) begin
        chk(req_ready == (m_st == 0), "R10 req_ready", 64'(req_ready), 64'(m_st == 0));
        chk(wlk_valid == (m_st == 1), "R9 wlk_valid", 64'(wlk_valid), 64'(m_st == 1));
        chk(rsp_valid == (m_st == 3), "R10 rsp_valid", 64'(rsp_valid), 64'(m_st == 3));
        if (m_st == 1) begin
            chk(wlk_ea == e_wea, "R9 wlk_ea", wlk_ea, e_wea);
            chk(wlk_lpid == e_wlpid && wlk_pid == e_wpid, m_tag,
                {wlk_lpid, wlk_pid}, {e_wlpid, e_wpid});
            chk(wlk_acc == e_wacc && wlk_prob == e_wprob, "R9 wlk_acc/prob",
                64'({wlk_acc, wlk_prob}), 64'({e_wacc, e_wprob}));
        end
        if (m_st == 3) begin
            chk(rsp_ra == e_ra, {m_tag, " ra"}, rsp_ra, e_ra);
            chk(rsp_psize == e_psz && rsp_prot == e_prot, {m_tag, " psize/prot"},
                64'({rsp_psize, rsp_prot}), 64'({e_psz, e_prot}));
            chk(rsp_exc == e_exc, {m_tag, " exc"}, 64'(rsp_exc), 64'(e_exc));
            chk(rsp_dar == e_dar, {m_tag, " dar"}, rsp_dar, e_dar);
            chk(rsp_dsisr == e_dsisr && rsp_err == e_err, {m_tag, " dsisr/err"},
                {rsp_dsisr, rsp_err}, {e_dsisr, e_err});
        end
    end

    // walker stub
    initial forever begin
        @(negedge clk);
        if (wlk_valid) begin
            repeat (g_rdy_dly) @(negedge clk);
            #1 wlk_ready = 1;
            @(posedge clk); #1 wlk_ready = 0;
            repeat (g_done_dly) @(negedge clk);
            #1 wlk_done = 1;
            @(posedge clk); #1 wlk_done = 0;
        end
    end

    task automatic run_req(input logic [63:0] ea, input logic [1:0] acc,
                           input bit hv, input bit pr, input bit ir, input bit dr);
        @(negedge clk); #1;
        req_ea = ea; req_acc = acc; msr_hv = hv; msr_pr = pr; msr_ir = ir; msr_dr = dr;
        req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1 req_valid = 0;
        while (!rsp_valid) @(negedge clk);
        repeat (g_ack_dly) @(negedge clk);
        #1 rsp_ack = 1;
        @(posedge clk); #1 rsp_ack = 0;
    endtask

    task automatic set_walk(input bit f, input logic [31:0] c, input logic [63:0] ra,
                            input logic [5:0] ps, input logic [2:0] pr);
        wlk_fault = f; wlk_cause = c; wlk_ra = ra; wlk_psize = ps; wlk_prot = pr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(req_ready && !wlk_valid && !rsp_valid, "R10 reset state",
            64'({req_ready, wlk_valid, rsp_valid}), 64'b100);
        // R1 real load, top nibble cleared
        run_req(64'hF234_5678_9ABC_DEF0, 2'd0, 0, 0, 1, 0);
        // R2 hv with bit63=0 -> offset ORed
        run_req(64'h7000_0000_0000_1234, 2'd2, 1, 0, 0, 1);
        // R2 hv with bit63=1 -> no offset
        run_req(64'h9000_0000_0000_5678, 2'd1, 1, 0, 1, 0);
        // R1 access code 3 behaves as a load
        run_req(64'hA000_0000_0000_0042, 2'd3, 0, 0, 1, 0);
        // R11 fetch relocated by ir, quadrant 0
        set_walk(0, 0, 64'h0000_1234_5000_0000, 6'd16, 3'b101);
        run_req(64'h0000_0000_0040_0000, 2'd2, 0, 1, 1, 0);
        // R4 load quadrant 0 with stalls
        g_rdy_dly = 2; g_done_dly = 3; g_ack_dly = 2;
        set_walk(0, 0, 64'h0000_0000_8888_0000, 6'd21, 3'b011);
        run_req(64'h0000_00AB_CDEF_0000, 2'd0, 0, 1, 1, 1);
        // R8 store fault quadrant 3 (store flag)
        set_walk(1, 32'h4000_0000, '0, '0, '0);
        run_req(64'hC000_0000_DEAD_0000, 2'd1, 0, 0, 1, 1);
        // R8 load fault, no store flag
        set_walk(1, 32'h0800_0000, '0, '0, '0);
        run_req(64'hC000_0000_BEEF_0000, 2'd0, 0, 0, 1, 1);
        // R7 fetch fault
        set_walk(1, 32'h1000_0000, '0, '0, '0);
        run_req(64'h0000_0000_0001_0000, 2'd2, 0, 1, 1, 1);
        // R6 segment faults
        g_rdy_dly = 0; g_done_dly = 0; g_ack_dly = 0;
        run_req(64'h4000_0000_0000_1000, 2'd2, 0, 0, 1, 1);
        run_req(64'h8000_0000_0000_2000, 2'd1, 0, 0, 1, 1);
        // mixed patterns
        for (int i = 0; i < 60; i++) begin
            g_rdy_dly = $urandom_range(0, 2);
            g_done_dly = $urandom_range(0, 3);
            g_ack_dly = $urandom_range(0, 2);
            set_walk(1'($urandom_range(0, 1)), $urandom(), {$urandom(), $urandom()},
                     6'($urandom_range(12, 30)), 3'($urandom_range(0, 7)));
            lpid_reg = 12'($urandom());
            pid_reg = 20'($urandom());
            hrmor = {$urandom(), $urandom()};
            run_req({$urandom(), $urandom()}, 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule